// File: doc/BRIEF.md
# Priority Pin Crossbar Decoder

This block places a fixed list of on-chip peripheral signals onto a bank of 32 external pins, arranged as four ports of eight bits each. Every peripheral group has its own enable bit. The enabled groups are packed onto the lowest usable pins in a fixed priority order. Switching one group on or off therefore moves every lower-priority function to a different pin. Pins on the designated analog port can be marked as analog. The packing skips such pins, and the crossbar never drives them. Any pin that no peripheral claims becomes general-purpose I/O, driven from a port output latch.

The assignment map is recomputed from the configuration inputs every clock and held in registers. A configuration change takes effect one cycle later. Peripheral values, output enables, latch values, drive modes and pad levels pass through combinationally. The block returns to each peripheral the level on its assigned pin. A peripheral that has no pin reads an idle 1. The raw pad levels are also returned for the port data registers.

Top module: `xbar_decoder`

## Requirements
- R1: Enabled groups are packed from pin 0 (port 0 bit 0) upward in this priority order and width: g0=2, g1=4, g2=2, g3=2, g4=6, g5=2, g6=8, g7=1, g8=1. grp_en bit g enables group g. Signal numbers run consecutively through the groups in that order (g0 holds signals 0-1, and so on up to g8, which holds signal 27), and the signals of a group stay in order.
- R2: A disabled group takes no pin. Every lower-priority signal moves down by the width of that group. Signals of a disabled group read 1 on per_in.
- R3: ana_sel bit i marks pin 8+i (port 1) as analog. The packing skips that pin, and it is never driven (pad_oe low).
- R4: A signal whose packed position falls past the last usable pin is not routed, and its per_in reads 1.
- R5: An unclaimed digital pin is general-purpose I/O driven from gpio_latch at the same bit.
- R6: pad_mode bit 1 selects push-pull, which drives both levels (pad_oe=1, pad_do=value). pad_mode bit 0 selects open-drain, which drives a 0 (pad_oe=1, pad_do=0) and releases the pin for a 1 (pad_oe=0).
- R7: A routed peripheral drives its pin only while its per_oe bit is 1. Groups g6 and g8 are input-only and never drive.
- R8: per_in of a routed signal equals the pad_in level of its assigned pin, combinationally.
- R9: port_rd always equals pad_in, whatever the pin is assigned to.
- R10: One cycle after xbar_en is seen low, every pin is released and every per_in reads 1.
- R11: Changes to grp_en, ana_sel and xbar_en take effect after exactly one clock edge. In reset and on leaving reset the map is empty, so no pin is driven and per_in is all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xbar_en | input | 1 | Global crossbar enable |
| grp_en | input | 9 | Per-group enable, bit g for group g |
| ana_sel | input | 8 | Analog mark for the port 1 pins |
| pad_mode | input | 32 | Per-pin drive mode: 1 push-pull, 0 open-drain |
| gpio_latch | input | 32 | Port output latch values |
| pad_in | input | 32 | Levels sensed on the pins |
| per_out | input | 28 | Peripheral output values per signal |
| per_oe | input | 28 | Peripheral output enables per signal |
| pad_oe | output | 32 | Per-pin drive enable |
| pad_do | output | 32 | Per-pin drive value |
| per_in | output | 28 | Pin level returned to each peripheral signal |
| port_rd | output | 32 | Pin levels for the port data registers |

## Verification
Analog exclusion and overflow can land in the same cycle. When every group is enabled, marking all of port 1 as analog removes eight usable pins. Signals that had fitted are then pushed past pin 31, and the pins they vacate also change. The bench applies this together with a check of the neighbouring signals. It judges the result by three things: the last signal that still fits must land on pin 31, the next one must read an idle 1, and the port 1 pins must stay released even though their owners are driving.

// File: rtl/xbar_pkg.sv
`timescale 1ns/1ps
// Package: group table of the pin crossbar.
// Holds the width and direction of each peripheral group, in priority
// order, plus the functions that derive signal-level tables from it.
// Assumes group order is the priority order (index 0 highest).
package xbar_pkg;
    localparam int NUM_GRP = 9;
    localparam int GRP_W [NUM_GRP] = '{2, 4, 2, 2, 6, 2, 8, 1, 1};
    localparam bit GRP_IN_ONLY [NUM_GRP] =
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

    // Total signal count across all groups.
    function automatic int sig_total();
        int acc = 0;
        for (int g = 0; g < NUM_GRP; g++) acc += GRP_W[g];
        return acc;
    endfunction

    localparam int NUM_SIG = sig_total();

    // Group that owns global signal number s.
    function automatic int grp_of(int s);
        int acc = 0;
        for (int g = 0; g < NUM_GRP; g++) begin
            acc += GRP_W[g];
            if (s < acc) return g;
        end
        return NUM_GRP - 1;
    endfunction

    // Per-signal mask of signals that may never drive a pin.
    function automatic logic [NUM_SIG-1:0] in_only_mask();
        logic [NUM_SIG-1:0] m;
        for (int s = 0; s < NUM_SIG; s++) m[s] = GRP_IN_ONLY[grp_of(s)];
        return m;
    endfunction
endpackage

// File: rtl/xbar_slot_map.sv
`timescale 1ns/1ps
// Module: assignment map of the crossbar.
// Ranks the enabled signals and the usable pins by running counts in
// priority order, matches equal ranks, and registers the result.
// Assumes the analog pins form one contiguous field starting at ANA_LO.
module xbar_slot_map #(
    parameter int NUM_PINS = 32,
    parameter int ANA_LO   = 8,
    parameter int ANA_W    = 8,
    parameter int NUM_SIG  = xbar_pkg::NUM_SIG,
    parameter int NUM_GRP  = xbar_pkg::NUM_GRP,
    parameter int SIG_W    = $clog2(NUM_SIG),
    parameter int PIN_W    = $clog2(NUM_PINS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             xbar_en,
    input  logic [NUM_GRP-1:0]               grp_en,
    input  logic [ANA_W-1:0]                 ana_sel,
    output logic                             live,
    output logic [NUM_PINS-1:0]              pin_dig,
    output logic [NUM_PINS-1:0]              pin_hit,
    output logic [NUM_PINS-1:0][SIG_W-1:0]   pin_own,
    output logic [NUM_SIG-1:0]               sig_hit,
    output logic [NUM_SIG-1:0][PIN_W-1:0]    sig_pin
);
    localparam int MAXN  = (NUM_SIG > NUM_PINS) ? NUM_SIG : NUM_PINS;
    localparam int CNT_W = $clog2(MAXN + 1);

    logic [NUM_SIG-1:0]              sig_use;
    logic [NUM_SIG-1:0][CNT_W-1:0]   sig_rank;
    logic [NUM_PINS-1:0][CNT_W-1:0]  pin_rank;
    logic [NUM_PINS-1:0]             dig_d;
    logic [CNT_W-1:0]                sig_cnt, pin_cnt;
    logic [NUM_PINS-1:0]             pin_hit_d;
    logic [NUM_PINS-1:0][SIG_W-1:0]  pin_own_d;
    logic [NUM_SIG-1:0]              sig_hit_d;
    logic [NUM_SIG-1:0][PIN_W-1:0]   sig_pin_d;

    // Each signal inherits the enable of its group.
    for (genvar s = 0; s < NUM_SIG; s++) begin : g_use
        localparam int G = xbar_pkg::grp_of(s);
        assign sig_use[s] = grp_en[G];
    end

    // Usable pins are all pins outside the analog-marked field.
    assign dig_d = ~(NUM_PINS'(ana_sel) << ANA_LO);

    // Running counts give each enabled signal and usable pin its rank.
    always_comb begin : rank_calc
        logic [CNT_W-1:0] n_sig, n_pin;
        n_sig = '0;
        n_pin = '0;
        for (int s = 0; s < NUM_SIG; s++) begin
            sig_rank[s] = n_sig;
            if (sig_use[s]) n_sig = n_sig + 1'b1;
        end
        for (int p = 0; p < NUM_PINS; p++) begin
            pin_rank[p] = n_pin;
            if (dig_d[p]) n_pin = n_pin + 1'b1;
        end
        sig_cnt = n_sig;
        pin_cnt = n_pin;
    end

    // Pair each usable pin with the enabled signal of equal rank.
    always_comb begin : match
        pin_hit_d = '0;
        pin_own_d = '0;
        sig_hit_d = '0;
        sig_pin_d = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            for (int s = 0; s < NUM_SIG; s++) begin
                if (xbar_en && sig_use[s] && dig_d[p] && sig_rank[s] == pin_rank[p]) begin
                    pin_hit_d[p] = 1'b1;
                    pin_own_d[p] = SIG_W'(s);
                    sig_hit_d[s] = 1'b1;
                    sig_pin_d[s] = PIN_W'(p);
                end
            end
        end
    end

    // Hold the map; reset leaves it empty and the crossbar bypassed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live    <= 1'b0;
            pin_dig <= '1;
            pin_hit <= '0;
            pin_own <= '0;
            sig_hit <= '0;
            sig_pin <= '0;
        end else begin
            live    <= xbar_en;
            pin_dig <= dig_d;
            pin_hit <= pin_hit_d;
            pin_own <= pin_own_d;
            sig_hit <= sig_hit_d;
            sig_pin <= sig_pin_d;
        end
    end

    // R4: routed signal count is the smaller of demand and usable pins.
    p_route_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> ($countones(sig_hit) ==
                  int'(($past(sig_cnt) < $past(pin_cnt)) ? $past(sig_cnt) : $past(pin_cnt))));

    // R1: pin-side and signal-side views of the map agree in size.
    p_map_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pin_hit) == $countones(sig_hit));
endmodule

// File: rtl/xbar_pin_drive.sv
`timescale 1ns/1ps
// Module: pad drive and return path of the crossbar.
// Chooses per pin between peripheral, port latch or release, applies the
// push-pull / open-drain mode, and returns pin levels to the peripherals.
// Assumes the map inputs come from registers (xbar_slot_map).
module xbar_pin_drive #(
    parameter int NUM_PINS = 32,
    parameter int NUM_SIG  = xbar_pkg::NUM_SIG,
    parameter int SIG_W    = $clog2(NUM_SIG),
    parameter int PIN_W    = $clog2(NUM_PINS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             live,
    input  logic [NUM_PINS-1:0]              pin_dig,
    input  logic [NUM_PINS-1:0]              pin_hit,
    input  logic [NUM_PINS-1:0][SIG_W-1:0]   pin_own,
    input  logic [NUM_SIG-1:0]               sig_hit,
    input  logic [NUM_SIG-1:0][PIN_W-1:0]    sig_pin,
    input  logic [NUM_SIG-1:0]               per_out,
    input  logic [NUM_SIG-1:0]               per_oe,
    input  logic [NUM_PINS-1:0]              gpio_latch,
    input  logic [NUM_PINS-1:0]              pad_mode,
    input  logic [NUM_PINS-1:0]              pad_in,
    output logic [NUM_PINS-1:0]              pad_oe,
    output logic [NUM_PINS-1:0]              pad_do,
    output logic [NUM_SIG-1:0]               per_in
);
    localparam logic [NUM_SIG-1:0] IN_ONLY = xbar_pkg::in_only_mask();

    // Select the source of each pin and shape it by drive mode.
    always_comb begin : drive
        for (int p = 0; p < NUM_PINS; p++) begin
            logic w_oe, w_val;
            w_oe  = 1'b0;
            w_val = 1'b0;
            if (live && pin_hit[p]) begin
                w_oe  = per_oe[pin_own[p]] & ~IN_ONLY[pin_own[p]];
                w_val = per_out[pin_own[p]];
            end else if (live && pin_dig[p]) begin
                w_oe  = 1'b1;
                w_val = gpio_latch[p];
            end
            pad_oe[p] = w_oe & (pad_mode[p] | ~w_val);
            pad_do[p] = w_oe & pad_mode[p] & w_val;
        end
    end

    // Routed signals see their pin; the rest read idle high.
    always_comb begin : ret
        for (int s = 0; s < NUM_SIG; s++)
            per_in[s] = (live && sig_hit[s]) ? pad_in[sig_pin[s]] : 1'b1;
    end

    // R6: an open-drain pin is never driven high.
    p_od_low_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~pad_mode & pad_do) == '0);
endmodule

// File: rtl/xbar_decoder.sv
`timescale 1ns/1ps
// Module: priority pin crossbar decoder (top).
// Packs enabled peripheral groups onto the lowest usable pins in fixed
// priority order, falls back to port latches elsewhere, and returns pin
// levels to the peripherals and the port data registers.
// Assumes one contiguous port (ANA_PORT) carries the analog marks.
module xbar_decoder #(
    parameter int PORT_CNT = 4,
    parameter int PORT_W   = 8,
    parameter int ANA_PORT = 1,
    parameter int NUM_PINS = PORT_CNT * PORT_W,
    parameter int NUM_SIG  = xbar_pkg::NUM_SIG,
    parameter int NUM_GRP  = xbar_pkg::NUM_GRP
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xbar_en,
    input  logic [NUM_GRP-1:0]  grp_en,
    input  logic [PORT_W-1:0]   ana_sel,
    input  logic [NUM_PINS-1:0] pad_mode,
    input  logic [NUM_PINS-1:0] gpio_latch,
    input  logic [NUM_PINS-1:0] pad_in,
    input  logic [NUM_SIG-1:0]  per_out,
    input  logic [NUM_SIG-1:0]  per_oe,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_do,
    output logic [NUM_SIG-1:0]  per_in,
    output logic [NUM_PINS-1:0] port_rd
);
    localparam int ANA_LO = ANA_PORT * PORT_W;
    localparam int SIG_W  = $clog2(NUM_SIG);
    localparam int PIN_W  = $clog2(NUM_PINS);

    logic                            live;
    logic [NUM_PINS-1:0]             pin_dig;
    logic [NUM_PINS-1:0]             pin_hit;
    logic [NUM_PINS-1:0][SIG_W-1:0]  pin_own;
    logic [NUM_SIG-1:0]              sig_hit;
    logic [NUM_SIG-1:0][PIN_W-1:0]   sig_pin;

    xbar_slot_map #(
        .NUM_PINS(NUM_PINS), .ANA_LO(ANA_LO), .ANA_W(PORT_W),
        .NUM_SIG(NUM_SIG), .NUM_GRP(NUM_GRP), .SIG_W(SIG_W), .PIN_W(PIN_W)
    ) u_map (
        .clk(clk), .rst_n(rst_n), .xbar_en(xbar_en), .grp_en(grp_en),
        .ana_sel(ana_sel), .live(live), .pin_dig(pin_dig),
        .pin_hit(pin_hit), .pin_own(pin_own),
        .sig_hit(sig_hit), .sig_pin(sig_pin)
    );

    xbar_pin_drive #(
        .NUM_PINS(NUM_PINS), .NUM_SIG(NUM_SIG), .SIG_W(SIG_W), .PIN_W(PIN_W)
    ) u_drv (
        .clk(clk), .rst_n(rst_n), .live(live), .pin_dig(pin_dig),
        .pin_hit(pin_hit), .pin_own(pin_own),
        .sig_hit(sig_hit), .sig_pin(sig_pin),
        .per_out(per_out), .per_oe(per_oe), .gpio_latch(gpio_latch),
        .pad_mode(pad_mode), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_do(pad_do), .per_in(per_in)
    );

    // R9: port data path reads the pads directly.
    assign port_rd = pad_in;

    // R10: crossbar off on the previous edge releases every pin.
    p_off_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(xbar_en) |-> (pad_oe == '0));

    // R3: analog-marked pins stay undriven.
    p_analog_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe[ANA_LO +: PORT_W] & $past(ana_sel)) == '0);
endmodule

// File: tb/sim_xbar_decoder.sv
`timescale 1ns/1ps
module sim_xbar_decoder;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        xbar_en;
    logic [8:0]  grp_en;
    logic [7:0]  ana_sel;
    logic [31:0] pad_mode, gpio_latch, pad_in, pad_oe, pad_do, port_rd;
    logic [27:0] per_out, per_oe, per_in;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    xbar_decoder u0 (
        .clk(clk), .rst_n(rst_n), .xbar_en(xbar_en), .grp_en(grp_en),
        .ana_sel(ana_sel), .pad_mode(pad_mode), .gpio_latch(gpio_latch),
        .pad_in(pad_in), .per_out(per_out), .per_oe(per_oe),
        .pad_oe(pad_oe), .pad_do(pad_do), .per_in(per_in), .port_rd(port_rd)
    );

    // {grp_en, ana_sel, signal, expected pin (63 = unrouted)}
    localparam logic [27:0] VEC [11] = '{
        {9'h1FF, 8'h00, 5'd27, 6'd27},   // R1 all groups, last signal
        {9'h1FF, 8'h00, 5'd10, 6'd10},   // R1
        {9'h082, 8'h00, 5'd26, 6'd4},    // R2 only g1 and g7
        {9'h082, 8'h00, 5'd3,  6'd1},    // R2
        {9'h1FE, 8'h00, 5'd27, 6'd25},   // R2 g0 off shifts all
        {9'h1FE, 8'h00, 5'd0,  6'd63},   // R2 disabled group idle
        {9'h1FF, 8'hFF, 5'd23, 6'd31},   // R3 port 1 analog
        {9'h1FF, 8'hFF, 5'd24, 6'd63},   // R4 overflow
        {9'h1FF, 8'h01, 5'd8,  6'd9},    // R3 one analog pin
        {9'h100, 8'h00, 5'd27, 6'd0},    // R1 lowest group alone
        {9'h050, 8'h0C, 5'd25, 6'd15}    // R3 skip inside packing
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; xbar_en = 1'b1; grp_en = 9'h1FF; ana_sel = 8'h00;
        pad_mode = '1; gpio_latch = '0; pad_in = '0; per_out = '0; per_oe = '1;
        repeat (3) step();
        check("R11 reset oe", pad_oe, 32'h0);
        check("R11 reset per_in", 32'(per_in), 32'h0FFF_FFFF);
        rst_n = 1'b1;
        per_oe = '0;

        // Table walk: map probed through the return path (R1 R2 R3 R4 R8).
        foreach (VEC[i]) begin
            logic [5:0] pin;
            logic [4:0] sg;
            step();
            grp_en = VEC[i][27:19]; ana_sel = VEC[i][18:11];
            sg = VEC[i][10:6]; pin = VEC[i][5:0];
            pad_in = (pin == 6'd63) ? 32'h0 : ~(32'h1 << pin);
            step();
            check($sformatf("R8 vec%0d low", i), 32'(per_in[sg]), (pin == 6'd63) ? 32'h1 : 32'h0);
            pad_in = (pin == 6'd63) ? 32'h0 : (32'h1 << pin);
            #1;
            check($sformatf("R4 vec%0d high", i), 32'(per_in[sg]), 32'h1);
        end

        // R5 and R11: GPIO fallback, then one-cycle map latency.
        grp_en = 9'h000; ana_sel = 8'h00; pad_mode = '1; gpio_latch = 32'hA5C3_0F96;
        step(); step();
        check("R5 gpio oe", pad_oe, 32'hFFFF_FFFF);
        check("R5 gpio do", pad_do, 32'hA5C3_0F96);
        grp_en = 9'h001;
        #1;
        check("R11 before edge", pad_oe, 32'hFFFF_FFFF);
        step();
        check("R11 after edge", pad_oe, 32'hFFFF_FFFC);

        // R6: open-drain and mixed modes on GPIO pins.
        grp_en = 9'h000; pad_mode = '0;
        step();
        check("R6 od oe", pad_oe, 32'h5A3C_F069);
        check("R6 od do", pad_do, 32'h0);
        pad_mode = 32'hFFFF_0000;
        #1;
        check("R6 mixed oe", pad_oe, 32'hFFFF_F069);
        check("R6 mixed do", pad_do, 32'hA5C3_0000);

        // R7: peripheral drive gated by its enable.
        grp_en = 9'h001; pad_mode = '1; gpio_latch = '0;
        per_out = 28'h1; per_oe = 28'h1;
        step();
        check("R7 oe gate", 32'(pad_oe[1:0]), 32'h1);
        check("R7 value", 32'(pad_do[0]), 32'h1);
        // R6: peripheral in open-drain, high released and low driven.
        pad_mode = '0; gpio_latch = '1; per_out = 28'h2; per_oe = 28'h3;
        #1;
        check("R6 od periph", pad_oe, 32'h0000_0001);
        // R7: input-only group never drives.
        grp_en = 9'h040; pad_mode = '1; gpio_latch = '0; per_out = '1; per_oe = '1;
        step();
        check("R7 input only", pad_oe, 32'hFFFF_FF00);

        // R3 with R4: analog port plus overflow, owners driving.
        grp_en = 9'h1FF; ana_sel = 8'hFF;
        step();
        check("R3 analog undriven", 32'(pad_oe[15:8]), 32'h0);
        pad_in = 32'h8000_0000;
        #1;
        check("R3 last fit", 32'(per_in[23]), 32'h1);
        pad_in = 32'h0;
        #1;
        check("R4 past end idle", 32'(per_in[25:23]), 32'h6);

        // R9: port read is the pad level.
        pad_in = 32'h1234_5678;
        #1;
        check("R9 port read", port_rd, 32'h1234_5678);

        // R10: crossbar off releases everything.
        xbar_en = 1'b0; pad_in = '0;
        step();
        check("R10 released", pad_oe, 32'h0);
        check("R10 per_in idle", 32'(per_in), 32'h0FFF_FFFF);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule